// File: doc/BRIEF.md
# Presettable Synchronous BCD Decade Counter

This block is a four-bit decimal digit counter. On each rising clock edge it moves through the digits 0 to 9 in 8421 code and wraps from 9 back to 0. Four control inputs choose what happens at each edge, in a fixed order of priority: clear, parallel load, count, then hold. The clear input and the load input are active low. The two count enables are active high. The clear can work in one of two ways, chosen by the `ASYNC_RESET` parameter. In the asynchronous form it forces the state to zero at once. In the synchronous form it clears the state at the next rising edge.

The terminal-count output is high when the state is 9 and the trickle enable is high. It feeds the enables of the next decade when several counters are chained. The six codes 10 to 15 have no meaning in BCD. They can enter the register through a preset or at power-up. Each of them has a defined successor, so the counter is back in the 0 to 9 sequence within two counts.

Top module: `bcd_decade_counter`

## Requirements
- R1: With clr_n, load_n, cnt_en_p and cnt_en_t all high, q advances by one at each rising edge through 0..9, and from 9 (4'b1001) it goes to 0.
- R2: Clear takes priority over load, and load takes priority over count. A low clr_n gives q = 0 whatever load_n and the enables are. A low load_n gives q = din whatever the enables are.
- R3: When ASYNC_RESET = 1, q becomes 0 as soon as clr_n goes low, between clock edges, and stays 0 while clr_n is low.
- R4: When ASYNC_RESET = 0, a low clr_n leaves q unchanged until the next rising edge, and at that edge q becomes 0.
- R5: With clr_n high and load_n low, q takes the value of din at the next rising edge. This includes the codes 10..15.
- R6: With clr_n and load_n high, q holds its value when cnt_en_p is low or when cnt_en_t is low.
- R7: tc is 1 exactly when q = 9 and cnt_en_t = 1. It is combinational and does not depend on cnt_en_p.
- R8: A count from an unused code gives the following successors: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2.
- R9: From any code 10..15, at most two counting edges bring q back to a value in 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous, set by ASYNC_RESET |
| load_n | input | 1 | Active-low parallel load enable |
| cnt_en_p | input | 1 | Parallel count enable, active high |
| cnt_en_t | input | 1 | Trickle count enable, active high; also gates tc |
| din | input | 4 | Parallel preset value |
| q | output | 4 | Counter state, 8421 code |
| tc | output | 1 | Terminal count: q = 9 and cnt_en_t high |

## Verification
The bound checker checks these rules on every clock edge:
- the priority of clear, load, count and hold;
- the count step and the wrap from 9 to 0;
- the hold when an enable is low;
- the gating of the terminal count;
- the successor of each unused code.

Two behaviours only the bench scenarios can show. The first is the timing of the clear between clock edges: immediate in one variant, held back to the edge in the other. The bench drives both variants side by side to show this. The second is the full walk from each loaded unused code back into the legal range within two counts.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;

    localparam int DIGIT_W    = 4;
    localparam int LAST_DIGIT = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } mode_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } ctrl_t;

    // Successor of a code under counting; unused codes fold back into 0..9.
    function automatic digit_t bcd_succ(input digit_t cur);
        digit_t nxt;
        case (cur)
            4'd9:    nxt = 4'd0;
            4'd10:   nxt = 4'd11;
            4'd11:   nxt = 4'd6;
            4'd12:   nxt = 4'd13;
            4'd13:   nxt = 4'd4;
            4'd14:   nxt = 4'd15;
            4'd15:   nxt = 4'd2;
            default: nxt = cur + digit_t'(1);
        endcase
        return nxt;
    endfunction

    function automatic logic is_last(input digit_t cur);
        return cur == digit_t'(LAST_DIGIT);
    endfunction

endpackage

// File: rtl/bcd_mode_sel.sv
`timescale 1ns/1ps
module bcd_mode_sel
    import bcd_pkg::*;
(
    input  ctrl_t ctrl,
    output mode_e mode
);
    always_comb begin
        if (!ctrl.clr_n)
            mode = MODE_CLEAR;
        else if (!ctrl.load_n)
            mode = MODE_LOAD;
        else if (ctrl.en_p && ctrl.en_t)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/bcd_next_state.sv
`timescale 1ns/1ps
module bcd_next_state
    import bcd_pkg::*;
(
    input  mode_e  mode,
    input  digit_t cur,
    input  digit_t preset,
    output digit_t nxt
);
    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = preset;
            MODE_COUNT: nxt = bcd_succ(cur);
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_state_reg.sv
`timescale 1ns/1ps
module bcd_state_reg
    import bcd_pkg::*;
#(
    parameter bit ASYNC_RESET = 1'b0
) (
    input  logic   clk,
    input  logic   clr_n,
    input  digit_t nxt,
    output digit_t cur
);
    generate
        if (ASYNC_RESET) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cur <= '0;
                else
                    cur <= nxt;
            end
        end else begin : g_sync
            // Clear already folded into nxt by the mode selector.
            logic unused_clr;
            assign unused_clr = clr_n;
            always_ff @(posedge clk) begin
                cur <= nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/bcd_decade_counter.sv
`timescale 1ns/1ps
module bcd_decade_counter
    import bcd_pkg::*;
#(
    parameter bit ASYNC_RESET = 1'b0
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               cnt_en_p,
    input  logic               cnt_en_t,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] q,
    output logic               tc
);
    ctrl_t  ctrl;
    mode_e  mode;
    digit_t nxt;
    digit_t cur;

    assign ctrl = '{clr_n: clr_n, load_n: load_n, en_p: cnt_en_p, en_t: cnt_en_t};

    bcd_mode_sel u_mode (
        .ctrl (ctrl),
        .mode (mode)
    );

    bcd_next_state u_next (
        .mode   (mode),
        .cur    (cur),
        .preset (din),
        .nxt    (nxt)
    );

    bcd_state_reg #(.ASYNC_RESET(ASYNC_RESET)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    assign q  = cur;
    assign tc = is_last(cur) && cnt_en_t;
endmodule

// File: rtl/bcd_decade_counter_chk.sv
`timescale 1ns/1ps
module bcd_decade_counter_chk
    import bcd_pkg::*;
#(
    parameter bit ASYNC_RESET = 1'b0
) (
    input logic               clk,
    input logic               clr_n,
    input logic               load_n,
    input logic               cnt_en_p,
    input logic               cnt_en_t,
    input logic [DIGIT_W-1:0] din,
    input logic [DIGIT_W-1:0] q,
    input logic               tc
);
    logic armed = 1'b0;
    logic counting;
    logic unused_param;

    assign unused_param = ASYNC_RESET;
    assign counting = clr_n && load_n && cnt_en_p && cnt_en_t;

    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    // R2 R3 R4: clear wins over everything at the edge
    assert_clear_R2: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> q == 4'd0);

    // R5: load takes din
    assert_load_R5: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (clr_n && !load_n) |=> q == $past(din));

    // R1: legal step
    assert_step_R1: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (counting && q < 4'd9) |=> q == 4'($past(q) + 4'd1));

    // R1: wrap
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (counting && q == 4'd9) |=> q == 4'd0);

    // R6: hold
    assert_hold_R6: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (clr_n && load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q));

    // R7: terminal count gating
    assert_tc_high_R7: assert property (@(posedge clk) disable iff (!armed)
        tc |-> (q == 4'd9 && cnt_en_t));
    assert_tc_on_R7: assert property (@(posedge clk) disable iff (!armed)
        (q == 4'd9 && cnt_en_t) |-> tc);

    // R8 R9: odd unused codes go legal in one count
    assert_odd_recover_R8: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (counting && q > 4'd9 && q[0]) |=> q <= 4'd9);

    // R8 R9: even unused codes step to the next odd unused code
    assert_even_step_R9: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (counting && q > 4'd9 && !q[0]) |=> (q == 4'($past(q) + 4'd1) && q[0]));
endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.ASYNC_RESET(ASYNC_RESET)) u_chk (.*);

// File: tb/bcd_decade_counter_bench.sv
`timescale 1ns/1ps
module bcd_decade_counter_bench;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en_p = 1'b0;
    logic       cnt_en_t = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q_s, q_a;
    logic       tc_s, tc_a;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bcd_decade_counter #(.ASYNC_RESET(1'b0)) u_bcd_decade_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
        .cnt_en_t(cnt_en_t), .din(din), .q(q_s), .tc(tc_s)
    );

    bcd_decade_counter #(.ASYNC_RESET(1'b1)) u_bcd_decade_counter_async (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
        .cnt_en_t(cnt_en_t), .din(din), .q(q_a), .tc(tc_a)
    );

    // Vector: {clr_n, load_n, cnt_en_p, cnt_en_t} nibble, din nibble, expected q nibble
    localparam int NV = 35;
    localparam logic [11:0] VEC [NV] = '{
        12'h700, 12'h350,
        12'hF01, 12'hF02, 12'hF03, 12'hF04, 12'hF05,
        12'hF06, 12'hF07, 12'hF08, 12'hF09, 12'hF00,
        12'hD00, 12'h888, 12'hF09, 12'hD09, 12'hE09, 12'hF00,
        12'h8AA, 12'hF0B, 12'hF06,
        12'h8CC, 12'hF0D, 12'hF04,
        12'h8EE, 12'hF0F, 12'hF02,
        12'h8BB, 12'hF06,
        12'h8DD, 12'hF04,
        12'h8FF, 12'hF02,
        12'hB33, 12'hF04
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] c, input logic [3:0] d);
        clr_n    = c[3];
        load_n   = c[2];
        cnt_en_p = c[1];
        cnt_en_t = c[0];
        din      = d;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Table walk: R1 R2 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][11:8], VEC[i][7:4]);
            step();
            check("R1/R2/R5/R6/R8 sync q", q_s, VEC[i][3:0]);
            check("R1/R2/R5/R6/R8 async q", q_a, VEC[i][3:0]);
            check("R7 tc", {3'b0, tc_s}, {3'b0, (VEC[i][3:0] == 4'd9) && VEC[i][8]});
        end

        // R7: tc independent of cnt_en_p, gated by cnt_en_t
        drive(4'h8, 4'd9); step();
        cnt_en_p = 1'b0; cnt_en_t = 1'b1; load_n = 1'b1; #0.5;
        check("R7 tc with p low", {3'b0, tc_s}, 4'd1);
        cnt_en_t = 1'b0; #0.5;
        check("R7 tc with t low", {3'b0, tc_s}, 4'd0);
        check("R6 hold at 9", q_s, 4'd9);

        // R9: every unused code legal within two counts
        for (int c = 10; c < 16; c++) begin
            drive(4'h8, 4'(c)); step();
            drive(4'hF, 4'd0); step(); step();
            check("R9 recovery", {3'b0, q_s <= 4'd9}, 4'd1);
        end

        // R3 R4: clear between edges
        drive(4'h8, 4'd7); step();
        drive(4'hC, 4'd0);
        #1;
        clr_n = 1'b0;
        #0.5;
        check("R3 async cleared at once", q_a, 4'd0);
        check("R4 sync waits for edge", q_s, 4'd7);
        step();
        check("R4 sync cleared at edge", q_s, 4'd0);
        check("R3 async stays clear", q_a, 4'd0);
        drive(4'hF, 4'd0); step();
        check("R1 count after clear", q_s, 4'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule